// File: doc/BRIEF.md
# Hsiao SEC-DED Codec for 32-bit Memory Words

This block guards 32-bit memory words with seven check bits from an odd-column-weight Hsiao code. The write side takes a data word and returns a 39-bit codeword ready to be stored. The read side takes a stored codeword and recomputes the check bits. It reports the resulting 7-bit syndrome and classifies the result as clean, a correctable single-bit error, or an uncorrectable multi-bit error. When it finds a single flipped data bit, it returns the data word with that bit repaired.

The two sides are independent combinational paths that share one constant parity-check matrix. A parameter, `REG_OUT`, adds one register stage on every output. The stage is enabled by default and is cleared by the synchronous active-low reset. The memory array and any error bookkeeping sit outside this block.

Top module: `hsiao_secded_codec`

## Requirements
- R1: Codeword layout. Bits 6..0 hold check bits c6..c0, and bits 38..7 hold data bits 31..0, with data bit i at codeword bit i+7.
- R2: Matrix. Take every 7-bit value with exactly three bits set, in ascending numeric order, and leave out 7, 25 and 98. Data bit i is given the i-th remaining value (i from 0) as its column. Check bit j is the XOR of all data bits whose column has bit j set.
- R3: Each data bit feeds exactly three check bits, so flipping one bit of the write data flips exactly three bits of the written check field. Each check bit covers 13 or 14 data bits.
- R4: Syndrome bit j is the check bit j recomputed from the read data field, XORed with the stored bit j. A clean codeword gives a zero syndrome, no flags, and the data field unchanged.
- R5: `err_any` is high exactly when the syndrome is nonzero.
- R6: A codeword with one flipped data bit gives a syndrome equal to that bit's column. It sets `err_single`, clears `err_multi`, and the output data equals the original data.
- R7: A codeword with one flipped check bit gives a one-hot syndrome at that bit's position. It sets `err_single`, and the output data equals the stored data field.
- R8: A nonzero syndrome with an even number of set bits sets `err_multi`, clears `err_single`, and passes the data field through unmodified.
- R9: An odd-weight syndrome that is neither one-hot nor equal to any data column sets `err_multi` and passes the data field through unmodified. Examples are weight 3 with value 7, 25 or 98, and weight 5 or 7.
- R10: With `REG_OUT`=1, every output reflects the inputs present at the previous rising clock edge. While `rst_n` is low at an edge, all outputs become zero.
- R11: The write and read paths are independent. A write input and a read input applied in the same cycle each produce their own correct results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_data | input | 32 | Data word to encode |
| wr_code | output | 39 | Encoded codeword (layout per R1) |
| rd_code | input | 39 | Stored codeword to check |
| rd_data | output | 32 | Data field, corrected when a single data bit is in error |
| syndrome | output | 7 | Recomputed check bits XOR stored check bits |
| err_any | output | 1 | Syndrome nonzero |
| err_single | output | 1 | Single-bit error, corrected or confined to a check bit |
| err_multi | output | 1 | Uncorrectable error, data passed unmodified |

## Verification
Encoding and decoding can be active in the same cycle, because the two paths share only the constant matrix. The bench drives a fresh write word together with a corrupted read codeword in a single cycle. It then judges the codeword and the decode results separately, each against its own reference. Every single-bit and every double-bit corruption of random codewords is also swept. Each result is compared with a syndrome predicted from the column rule, and the flags and data are checked.

// File: rtl/hsiao_pkg.sv
// Package hsiao_pkg
// Shared widths and the constant parity-check matrix of the Hsiao code.
// Assumes 32 data bits and 7 check bits; the column rule is computed, not tabulated.
package hsiao_pkg;
    localparam int DATA_W = 32;
    localparam int CHK_W  = 7;
    localparam int CODE_W = DATA_W + CHK_W;
    localparam int COL_WEIGHT = 3;

    typedef logic [CHK_W-1:0]  chk_t;
    typedef logic [DATA_W-1:0] data_t;
    typedef logic [CODE_W-1:0] code_t;

    // Excluded weight-3 values chosen so that row weights settle at 13 or 14
    localparam chk_t SKIP_A = 7'd7;
    localparam chk_t SKIP_B = 7'd25;
    localparam chk_t SKIP_C = 7'd98;

    // Builds the flattened matrix: column i occupies bits [i*CHK_W +: CHK_W]
    function automatic logic [DATA_W*CHK_W-1:0] build_matrix();
        logic [DATA_W*CHK_W-1:0] m;
        int n;
        m = '0;
        n = 0;
        for (int v = 0; v < (1 << CHK_W); v++) begin
            if ($countones(v[CHK_W-1:0]) == COL_WEIGHT &&
                v[CHK_W-1:0] != SKIP_A && v[CHK_W-1:0] != SKIP_B &&
                v[CHK_W-1:0] != SKIP_C && n < DATA_W) begin
                m[n*CHK_W +: CHK_W] = v[CHK_W-1:0];
                n++;
            end
        end
        return m;
    endfunction

    localparam logic [DATA_W*CHK_W-1:0] H_MATRIX = build_matrix();

    // Check bits of a data word: XOR of the columns of all set data bits
    function automatic chk_t check_bits(data_t d);
        chk_t c;
        c = '0;
        for (int i = 0; i < DATA_W; i++)
            if (d[i]) c ^= H_MATRIX[i*CHK_W +: CHK_W];
        return c;
    endfunction
endpackage

// File: rtl/hsiao_encoder.sv
// Module hsiao_encoder
// Combinational write path: appends the seven check bits below the data word.
// Assumes the codeword layout {data, check} with check bits in the low positions.
module hsiao_encoder
    import hsiao_pkg::*;
(
    input  data_t data_in,
    output code_t code_out
);
    // Pack data above the computed check field
    always_comb begin
        code_out = {data_in, check_bits(data_in)};
    end
endmodule

// File: rtl/hsiao_decoder.sv
// Module hsiao_decoder
// Combinational read path: syndrome, error classification and single-bit repair.
// Assumes every data column is a distinct weight-3 vector, so an odd syndrome
// that is neither one-hot nor a column cannot come from a single flip.
module hsiao_decoder
    import hsiao_pkg::*;
(
    input  code_t code_in,
    output data_t data_out,
    output chk_t  syn_out,
    output logic  any_out,
    output logic  single_out,
    output logic  multi_out
);
    data_t raw_data;
    chk_t  raw_chk;
    chk_t  syn;
    data_t flip_mask;
    logic  odd_syn;
    logic  chk_hit;

    // Split the codeword and form the syndrome
    always_comb begin
        raw_data = code_in[CODE_W-1:CHK_W];
        raw_chk  = code_in[CHK_W-1:0];
        syn      = check_bits(raw_data) ^ raw_chk;
    end

    // One comparator per data column marks the bit to invert
    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_match
        localparam chk_t COL = H_MATRIX[gi*CHK_W +: CHK_W];
        assign flip_mask[gi] = (syn == COL);
    end

    // Classify the syndrome by its OR, its parity and its match result
    always_comb begin
        odd_syn    = ^syn;
        chk_hit    = ($countones(syn) == 1);
        any_out    = |syn;
        single_out = odd_syn && (chk_hit || (|flip_mask));
        multi_out  = any_out && !single_out;
        syn_out    = syn;
        data_out   = raw_data ^ flip_mask;
    end
endmodule

// File: rtl/hsiao_outstage.sv
// Module hsiao_outstage
// Optional register stage for all codec outputs; pass-through when ENABLE is 0.
// Assumes synchronous active-low reset clears every registered output to zero.
module hsiao_outstage #(
    parameter bit ENABLE = 1'b1,
    parameter int WIDTH  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q_out
);
    if (ENABLE) begin : g_reg
        logic [WIDTH-1:0] q_r;
        // Capture outputs on each edge, clear under reset
        always_ff @(posedge clk) begin
            if (!rst_n) q_r <= '0;
            else        q_r <= d_in;
        end
        assign q_out = q_r;
    end else begin : g_wire
        assign q_out = d_in;
    end
endmodule

// File: rtl/hsiao_secded_codec.sv
// Module hsiao_secded_codec
// Top of the SEC-DED codec: independent encoder and decoder, plus an optional
// output register stage selected by REG_OUT. Assumes a single clock domain.
module hsiao_secded_codec
    import hsiao_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       wr_data,
    output logic [38:0]       wr_code,
    input  logic [38:0]       rd_code,
    output logic [31:0]       rd_data,
    output logic [6:0]        syndrome,
    output logic              err_any,
    output logic              err_single,
    output logic              err_multi
);
    localparam int BUNDLE_W = CODE_W + DATA_W + CHK_W + 3;

    code_t enc_code;
    data_t dec_data;
    chk_t  dec_syn;
    logic  dec_any, dec_single, dec_multi;
    logic [BUNDLE_W-1:0] bundle_d, bundle_q;

    hsiao_encoder u_enc (
        .data_in  (wr_data),
        .code_out (enc_code)
    );

    hsiao_decoder u_dec (
        .code_in    (rd_code),
        .data_out   (dec_data),
        .syn_out    (dec_syn),
        .any_out    (dec_any),
        .single_out (dec_single),
        .multi_out  (dec_multi)
    );

    // Gather every output into one bundle for the optional stage
    always_comb begin
        bundle_d = {enc_code, dec_data, dec_syn, dec_any, dec_single, dec_multi};
    end

    hsiao_outstage #(.ENABLE(REG_OUT), .WIDTH(BUNDLE_W)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (bundle_d),
        .q_out (bundle_q)
    );

    assign {wr_code, rd_data, syndrome, err_any, err_single, err_multi} = bundle_q;

    // Decoder classification guards
    a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(dec_single && dec_multi));

    a_r5_any_matches_class: assert property (@(posedge clk) disable iff (!rst_n)
        dec_any == (dec_single || dec_multi));

    a_r6_one_bit_repaired: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_single && $countones(dec_syn) == 3) |->
        ($countones(dec_data ^ rd_code[CODE_W-1:CHK_W]) == 1));

    a_r7_check_flip_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_single && $onehot(dec_syn)) |-> (dec_data == rd_code[CODE_W-1:CHK_W]));

    a_r8_multi_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
        dec_multi |-> (dec_data == rd_code[CODE_W-1:CHK_W]));

    // Encoder output must be a codeword the decoder accepts
    a_r4_encoder_data_field: assert property (@(posedge clk) disable iff (!rst_n)
        enc_code[CODE_W-1:CHK_W] == wr_data);
endmodule

// File: tb/hsiao_secded_codec_bench.sv
module hsiao_secded_codec_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] wr_data = '0;
    logic [38:0] wr_code;
    logic [38:0] rd_code = '0;
    logic [31:0] rd_data;
    logic [6:0]  syndrome;
    logic        err_any, err_single, err_multi;

    int checks = 0;
    int errors = 0;
    logic [6:0] cols [32];

    always #2.5 clk = ~clk;

    hsiao_secded_codec u_hsiao_secded_codec (
        .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_code(wr_code),
        .rd_code(rd_code), .rd_data(rd_data), .syndrome(syndrome),
        .err_any(err_any), .err_single(err_single), .err_multi(err_multi)
    );

    function automatic logic [6:0] ref_chk(logic [31:0] d);
        logic [6:0] c = '0;
        for (int i = 0; i < 32; i++) if (d[i]) c ^= cols[i];
        return c;
    endfunction

    function automatic logic [38:0] ref_code(logic [31:0] d);
        return {d, ref_chk(d)};
    endfunction

    function automatic logic [6:0] bit_syn(int b);
        return (b < 7) ? 7'(1 << b) : cols[b-7];
    endfunction

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic apply(logic [31:0] wd, logic [38:0] rc);
        @(negedge clk);
        wr_data = wd;
        rd_code = rc;
        @(negedge clk);
    endtask

    task automatic expect_read(string req, logic [38:0] rc, logic [31:0] dexp,
                               logic [6:0] sexp, logic s, logic m);
        apply(wr_data, rc);
        chk(req, "syndrome", 64'(syndrome), 64'(sexp));
        chk(req, "data", 64'(rd_data), 64'(dexp));
        chk(req, "flags", 64'({err_any, err_single, err_multi}),
            64'({sexp != 0, s, m}));
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        wr_data = 32'hFFFF_FFFF;
        rd_code = '1;
        @(negedge clk); @(negedge clk);
        chk("R10", "reset outputs", 64'({wr_code, rd_data, syndrome, err_any, err_single, err_multi}), 64'(0));
        rst_n = 1'b1;
    endtask

    task automatic t_encode();
        logic [31:0] w [4] = '{32'h0, 32'hFFFF_FFFF, 32'hDEAD_BEEF, 32'h1234_5678};
        foreach (w[k]) begin
            apply(w[k], '0);
            chk("R1", "codeword layout", 64'(wr_code), 64'(ref_code(w[k])));
        end
        // R3: single data bit moves three check bits; row weights 13 or 14
        for (int i = 0; i < 32; i++) begin
            apply(32'(1) << i, '0);
            chk("R3", "check weight", 64'($countones(wr_code[6:0])), 64'd3);
        end
        for (int j = 0; j < 7; j++) begin
            int cnt = 0;
            for (int i = 0; i < 32; i++) cnt += cols[i][j];
            chk("R2", "row weight in range", 64'(cnt == 13 || cnt == 14), 64'd1);
        end
    endtask

    task automatic t_clean();
        for (int k = 0; k < 4; k++) begin
            logic [31:0] d = $urandom;
            expect_read("R4", ref_code(d), d, 7'd0, 1'b0, 1'b0);
        end
    endtask

    task automatic t_single();
        for (int k = 0; k < 3; k++) begin
            logic [31:0] d = $urandom;
            logic [38:0] c = ref_code(d);
            for (int b = 0; b < 39; b++)
                expect_read(b < 7 ? "R7" : "R6", c ^ (39'(1) << b), d, bit_syn(b), 1'b1, 1'b0);
        end
    endtask

    task automatic t_double();
        logic [31:0] d = $urandom;
        logic [38:0] c = ref_code(d);
        for (int a = 0; a < 39; a++)
            for (int b = a + 1; b < 39; b++) begin
                logic [38:0] bad = c ^ (39'(1) << a) ^ (39'(1) << b);
                expect_read("R8", bad, bad[38:7], bit_syn(a) ^ bit_syn(b), 1'b0, 1'b1);
            end
    endtask

    task automatic t_odd_unmatched();
        logic [31:0] d = 32'hA5A5_0F0F;
        logic [38:0] c = ref_code(d);
        expect_read("R9", c ^ 39'h07, d, 7'd7, 1'b0, 1'b1);
        expect_read("R9", c ^ 39'd25, d, 7'd25, 1'b0, 1'b1);
        expect_read("R9", c ^ 39'd98, d, 7'd98, 1'b0, 1'b1);
        expect_read("R9", c ^ 39'h1F, d, 7'h1F, 1'b0, 1'b1);
        expect_read("R9", c ^ 39'h7F, d, 7'h7F, 1'b0, 1'b1);
    endtask

    task automatic t_concurrent();
        logic [31:0] dw = 32'hCAFE_F00D;
        logic [31:0] dr = 32'h0BAD_C0DE;
        logic [38:0] bad = ref_code(dr) ^ (39'(1) << 20);
        apply(dw, bad);
        chk("R11", "write side", 64'(wr_code), 64'(ref_code(dw)));
        chk("R11", "read data", 64'(rd_data), 64'(dr));
        chk("R11", "read flags", 64'({err_single, syndrome}), 64'({1'b1, cols[13]}));
        // R10: output tracks the previous edge, so one more cycle changes it
        @(negedge clk);
        wr_data = 32'h0;
        chk("R10", "held until edge", 64'(wr_code), 64'(ref_code(dw)));
        @(negedge clk);
        chk("R10", "updated after edge", 64'(wr_code), 64'(ref_code(32'h0)));
    endtask

    initial begin
        int n = 0;
        for (int v = 0; v < 128; v++)
            if ($countones(v) == 3 && v != 7 && v != 25 && v != 98 && n < 32) begin
                cols[n] = 7'(v);
                n++;
            end
        t_reset();
        t_encode();
        t_clean();
        t_single();
        t_double();
        t_odd_unmatched();
        t_concurrent();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule